// File: doc/BRIEF.md
# Per-Port Packet Framing Checker

This block sits beside a packet transfer stream in which every transfer carries a logical port number, a start marker, an end marker and a byte count. For each logical port it records whether a packet is open and how many bytes that packet has gathered so far. From this it detects two framing faults. A start marker on a port that already has an open packet is one fault. An end marker on a port with no open packet is the other. It also polices the length of every packet that completes.

Each fault is reported as a one-cycle pulse at the level of the whole physical stream, with no port number attached. When a packet completes, its length is compared with a programmable lower limit and a programmable upper limit. Each limit has its own saturating counter, and each counter has its own enable. The block stores no payload. It keeps all per-port state in registers, so a transfer can follow another transfer in the next cycle, on the same port or on any other port.

Top module: `pfc_framing_check`

## Requirements
- R1: The length of a packet is the sum of the `xfer_bytes` values of all its transfers, from the start-marked transfer through the end-marked transfer. Each logical port keeps its own open flag and length, so interleaving transfers of different ports does not change any port's result.
- R2: A transfer with `xfer_sop`=1 on a port whose packet is open raises `evt_bad_sop` for exactly the next cycle. The open packet is discarded with no length check, and a new packet starts with this transfer's bytes. If `xfer_eop` is also 1, that new packet completes at once.
- R3: A transfer with `xfer_eop`=1 and `xfer_sop`=0 on a port with no open packet raises `evt_bad_eop` for exactly the next cycle. The transfer is dropped, and neither counter changes because of it.
- R4: The fault outputs are single bits that carry no logical port identity. They are never high in the same cycle.
- R5: A completed packet whose length is less than `cfg_min_len` (0 to 255) adds one to `short_count` when `cfg_short_en` is 1 in the completing cycle. The new value is visible in the next cycle. A length equal to the limit is not short.
- R6: A completed packet whose length is greater than `cfg_max_len` (0 to 16383) adds one to `long_count` when `cfg_long_en` is 1 in the completing cycle. The new value is visible in the next cycle. A length equal to the limit is not long.
- R7: While `cfg_short_en` or `cfg_long_en` is 0, the matching counter holds its value whatever packet lengths complete.
- R8: The running length of a packet saturates at 16384. A packet longer than 16383 bytes is therefore always counted as long, even if it exceeds 32767 bytes.
- R9: `short_count` and `long_count` are CNT_W bits wide (default 32) and stop at all ones.
- R10: Transfers are accepted on every cycle with `xfer_valid`=1, with no idle cycles needed, including consecutive transfers on the same port.
- R11: A transfer with neither marker on a port with no open packet is ignored. It raises no fault and does not add to any later packet's length.
- R12: Synchronous reset closes every port and clears both counters and both fault outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_valid | input | 1 | A transfer is present this cycle |
| xfer_port | input | IDX_W | Logical port number of the transfer |
| xfer_sop | input | 1 | Transfer opens a packet |
| xfer_eop | input | 1 | Transfer closes a packet |
| xfer_bytes | input | BYTE_W | Number of valid bytes in the transfer |
| cfg_min_len | input | 8 | Lower length limit in bytes |
| cfg_max_len | input | 14 | Upper length limit in bytes |
| cfg_short_en | input | 1 | Enables counting of short packets |
| cfg_long_en | input | 1 | Enables counting of long packets |
| evt_bad_sop | output | 1 | Pulse: start marker arrived while a packet was open |
| evt_bad_eop | output | 1 | Pulse: end marker arrived with no packet open |
| short_count | output | CNT_W | Saturating count of short packets |
| long_count | output | CNT_W | Saturating count of long packets |

## Verification
The bench targets the exact limit values. It checks lengths of min-1, min, max and max+1, and catches a design that uses the wrong comparison by one count that is missing or one too many. It sends a packet of more than 32767 bytes. A length register that wraps would drop back below the upper limit and miss the long count. Double start and double end markers are checked for the pulse, for the discard of the stale packet, and for the dropped end marker. A design that checked the stale packet, or that added the dropped end marker's bytes to the length, would show a wrong counter value. Interleaved back-to-back transfers on two ports, a reset while a packet is open, and a counter driven past all ones complete the set. These catch state shared between ports, a reset that leaves state behind, and a counter that wraps.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int LEN_W   = 15;
    localparam int LEN_CAP = 16384;
    localparam int MIN_W   = 8;
    localparam int MAX_W   = 14;

    typedef logic [LEN_W-1:0] plen_t;

    typedef struct packed {
        logic  open;
        plen_t len;
    } port_state_t;

    typedef struct packed {
        logic  bad_sop;
        logic  bad_eop;
        logic  done;
        plen_t done_len;
    } seq_result_t;

    // Add with a ceiling so that a huge packet never wraps into a legal length
    function automatic plen_t len_add_sat(plen_t base, plen_t inc);
        logic [LEN_W:0] sum;
        sum = {1'b0, base} + {1'b0, inc};
        if (sum > (LEN_W+1)'(LEN_CAP)) begin
            return plen_t'(LEN_CAP);
        end
        return sum[LEN_W-1:0];
    endfunction

endpackage

// File: rtl/pfc_state_table.sv
module pfc_state_table
    import pfc_pkg::*;
#(
    parameter int PORTS = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output port_state_t      rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  port_state_t      wr_state
);

    port_state_t entry [PORTS];

    for (genvar i = 0; i < PORTS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                entry[i] <= wr_state;
            end
        end
    end

    always_comb begin
        rd_state = '0;
        if (int'(rd_idx) < PORTS) begin
            rd_state = entry[rd_idx];
        end
    end

endmodule

// File: rtl/pfc_seq_engine.sv
module pfc_seq_engine
    import pfc_pkg::*;
#(
    parameter int BYTE_W = 3
) (
    input  logic              valid,
    input  logic              sop,
    input  logic              eop,
    input  logic [BYTE_W-1:0] bytes,
    input  port_state_t       cur,
    output port_state_t       nxt,
    output logic              wr_en,
    output seq_result_t       res
);

    plen_t inc;
    plen_t fresh;
    plen_t grown;

    assign inc   = plen_t'(bytes);
    assign fresh = len_add_sat('0, inc);
    assign grown = len_add_sat(cur.len, inc);

    always_comb begin
        nxt   = cur;
        wr_en = 1'b0;
        res   = '0;
        if (valid) begin
            wr_en = 1'b1;
            if (sop) begin
                // a stale open packet is dropped unchecked
                res.bad_sop = cur.open;
                if (eop) begin
                    res.done     = 1'b1;
                    res.done_len = fresh;
                    nxt.open     = 1'b0;
                    nxt.len      = '0;
                end else begin
                    nxt.open = 1'b1;
                    nxt.len  = fresh;
                end
            end else if (eop) begin
                if (cur.open) begin
                    res.done     = 1'b1;
                    res.done_len = grown;
                    nxt.open     = 1'b0;
                    nxt.len      = '0;
                end else begin
                    res.bad_eop = 1'b1;
                end
            end else if (cur.open) begin
                nxt.len = grown;
            end
        end
    end

endmodule

// File: rtl/pfc_sat_counter.sv
module pfc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && !(&count)) begin
            count <= count + W'(1);
        end
    end

endmodule

// File: rtl/pfc_len_police.sv
module pfc_len_police
    import pfc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  plen_t            len,
    input  logic [MIN_W-1:0] min_len,
    input  logic [MAX_W-1:0] max_len,
    input  logic             short_en,
    input  logic             long_en,
    output logic [CNT_W-1:0] short_count,
    output logic [CNT_W-1:0] long_count
);

    localparam int NCNT = 2;

    logic [NCNT-1:0]  hit;
    logic [NCNT-1:0]  en;
    logic [CNT_W-1:0] cnt [NCNT];

    assign hit[0] = done && (len < plen_t'(min_len));
    assign hit[1] = done && (len > plen_t'(max_len));
    assign en[0]  = short_en;
    assign en[1]  = long_en;

    for (genvar k = 0; k < NCNT; k++) begin : g_cnt
        pfc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (hit[k] && en[k]),
            .count (cnt[k])
        );
    end

    assign short_count = cnt[0];
    assign long_count  = cnt[1];

endmodule

// File: rtl/pfc_framing_check.sv
module pfc_framing_check
    import pfc_pkg::*;
#(
    parameter int  PORTS  = 64,
    parameter int  BYTE_W = 3,
    parameter int  CNT_W  = 32,
    localparam int IDX_W  = (PORTS > 1) ? $clog2(PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  logic [IDX_W-1:0]  xfer_port,
    input  logic              xfer_sop,
    input  logic              xfer_eop,
    input  logic [BYTE_W-1:0] xfer_bytes,
    input  logic [MIN_W-1:0]  cfg_min_len,
    input  logic [MAX_W-1:0]  cfg_max_len,
    input  logic              cfg_short_en,
    input  logic              cfg_long_en,
    output logic              evt_bad_sop,
    output logic              evt_bad_eop,
    output logic [CNT_W-1:0]  short_count,
    output logic [CNT_W-1:0]  long_count
);

    port_state_t cur_state;
    port_state_t nxt_state;
    logic        st_wr;
    seq_result_t seq_res;

    pfc_state_table #(.PORTS(PORTS), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (xfer_port),
        .rd_state (cur_state),
        .wr_en    (st_wr),
        .wr_idx   (xfer_port),
        .wr_state (nxt_state)
    );

    pfc_seq_engine #(.BYTE_W(BYTE_W)) u_seq (
        .valid (xfer_valid),
        .sop   (xfer_sop),
        .eop   (xfer_eop),
        .bytes (xfer_bytes),
        .cur   (cur_state),
        .nxt   (nxt_state),
        .wr_en (st_wr),
        .res   (seq_res)
    );

    pfc_len_police #(.CNT_W(CNT_W)) u_police (
        .clk         (clk),
        .rst         (rst),
        .done        (seq_res.done),
        .len         (seq_res.done_len),
        .min_len     (cfg_min_len),
        .max_len     (cfg_max_len),
        .short_en    (cfg_short_en),
        .long_en     (cfg_long_en),
        .short_count (short_count),
        .long_count  (long_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_bad_sop <= 1'b0;
            evt_bad_eop <= 1'b0;
        end else begin
            evt_bad_sop <= seq_res.bad_sop;
            evt_bad_eop <= seq_res.bad_eop;
        end
    end

endmodule

// File: rtl/pfc_framing_check_chk.sv
module pfc_framing_check_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             xfer_valid,
    input logic             xfer_sop,
    input logic             xfer_eop,
    input logic             cfg_short_en,
    input logic             cfg_long_en,
    input logic             evt_bad_sop,
    input logic             evt_bad_eop,
    input logic [CNT_W-1:0] short_count,
    input logic [CNT_W-1:0] long_count
);

    // R4
    evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt_bad_sop, evt_bad_eop}));

    // R2
    bad_sop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        evt_bad_sop |-> $past(xfer_valid && xfer_sop));

    // R3
    bad_eop_cause_chk: assert property (@(posedge clk) disable iff (rst)
        evt_bad_eop |-> $past(xfer_valid && xfer_eop && !xfer_sop));

    // R5
    short_step_chk: assert property (@(posedge clk) disable iff (rst)
        (short_count != $past(short_count)) |-> (short_count == $past(short_count) + CNT_W'(1)));

    // R6
    long_step_chk: assert property (@(posedge clk) disable iff (rst)
        (long_count != $past(long_count)) |-> (long_count == $past(long_count) + CNT_W'(1)));

    // R7
    short_off_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_short_en) |-> $stable(short_count));

    // R7
    long_off_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_long_en) |-> $stable(long_count));

    // R9
    short_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (&$past(short_count)) |-> (&short_count));

    // R9
    long_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (&$past(long_count)) |-> (&long_count));

endmodule

bind pfc_framing_check pfc_framing_check_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .xfer_valid   (xfer_valid),
    .xfer_sop     (xfer_sop),
    .xfer_eop     (xfer_eop),
    .cfg_short_en (cfg_short_en),
    .cfg_long_en  (cfg_long_en),
    .evt_bad_sop  (evt_bad_sop),
    .evt_bad_eop  (evt_bad_eop),
    .short_count  (short_count),
    .long_count   (long_count)
);

// File: tb/pfc_framing_check_bench.sv
`timescale 1ns/1ps
module pfc_framing_check_bench;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xfer_valid = 1'b0;
    logic [5:0]    xfer_port = '0;
    logic          xfer_sop = 1'b0;
    logic          xfer_eop = 1'b0;
    logic [2:0]    xfer_bytes = '0;
    logic [7:0]    cfg_min_len = 8'd8;
    logic [13:0]   cfg_max_len = 14'd20;
    logic          cfg_short_en = 1'b1;
    logic          cfg_long_en = 1'b1;
    logic          evt_bad_sop;
    logic          evt_bad_eop;
    logic [CW-1:0] short_count;
    logic [CW-1:0] long_count;

    int total = 0;
    int bad = 0;
    int n_bsop = 0;
    int n_beop = 0;
    logic got_bsop = 1'b0;
    logic got_beop = 1'b0;

    always #5 clk = ~clk;

    pfc_framing_check #(.PORTS(64), .BYTE_W(3), .CNT_W(CW)) u_pfc_framing_check (
        .clk          (clk),
        .rst          (rst),
        .xfer_valid   (xfer_valid),
        .xfer_port    (xfer_port),
        .xfer_sop     (xfer_sop),
        .xfer_eop     (xfer_eop),
        .xfer_bytes   (xfer_bytes),
        .cfg_min_len  (cfg_min_len),
        .cfg_max_len  (cfg_max_len),
        .cfg_short_en (cfg_short_en),
        .cfg_long_en  (cfg_long_en),
        .evt_bad_sop  (evt_bad_sop),
        .evt_bad_eop  (evt_bad_eop),
        .short_count  (short_count),
        .long_count   (long_count)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send(input int p, input bit s, input bit e, input int b);
        @(negedge clk);
        xfer_valid = 1'b1;
        xfer_port  = p[5:0];
        xfer_sop   = s;
        xfer_eop   = e;
        xfer_bytes = b[2:0];
        @(posedge clk);
        #1;
        got_bsop = evt_bad_sop;
        got_beop = evt_bad_eop;
        if (got_bsop) n_bsop++;
        if (got_beop) n_beop++;
        if (got_bsop && got_beop) chk("R4 both faults in one cycle", 1, 0);
    endtask

    task automatic idle();
        @(negedge clk);
        xfer_valid = 1'b0;
        xfer_sop   = 1'b0;
        xfer_eop   = 1'b0;
    endtask

    task automatic send_pkt(input int p, input int len);
        int rem;
        if (len <= 4) begin
            send(p, 1'b1, 1'b1, len);
        end else begin
            send(p, 1'b1, 1'b0, 4);
            rem = len - 4;
            while (rem > 4) begin
                send(p, 1'b0, 1'b0, 4);
                rem -= 4;
            end
            send(p, 1'b0, 1'b1, rem);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        xfer_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R12 short_count after reset", int'(short_count), 0);
        chk("R12 long_count after reset", int'(long_count), 0);
        chk("R12 faults after reset", int'({evt_bad_sop, evt_bad_eop}), 0);
        send(9, 1'b1, 1'b0, 4);
        idle();
        do_reset();
        send(9, 1'b0, 1'b1, 4);
        chk("R12 open packet cleared by reset", int'(got_beop), 1);
        idle();
    endtask

    task automatic t_normal();
        int s0 = int'(short_count);
        int l0 = int'(long_count);
        int f0 = n_bsop + n_beop;
        send(3, 1'b1, 1'b0, 4);
        send(3, 1'b0, 1'b0, 4);
        send(3, 1'b0, 1'b1, 2);
        idle();
        chk("R1 legal 10-byte packet short", int'(short_count), s0);
        chk("R1 legal 10-byte packet long", int'(long_count), l0);
        chk("R10 back-to-back no faults", n_bsop + n_beop, f0);
    endtask

    task automatic t_limits();
        int s0 = int'(short_count);
        int l0 = int'(long_count);
        send_pkt(4, 7);
        chk("R5 length min-1 is short", int'(short_count), s0 + 1);
        send_pkt(4, 8);
        chk("R5 length equal to min not short", int'(short_count), s0 + 1);
        send_pkt(4, 20);
        chk("R6 length equal to max not long", int'(long_count), l0);
        send_pkt(4, 21);
        chk("R6 length max+1 is long", int'(long_count), l0 + 1);
        idle();
    endtask

    task automatic t_disabled();
        int s0 = int'(short_count);
        int l0 = int'(long_count);
        cfg_short_en = 1'b0;
        cfg_long_en  = 1'b0;
        send_pkt(6, 2);
        send_pkt(6, 30);
        idle();
        @(negedge clk);
        chk("R7 short counting disabled", int'(short_count), s0);
        chk("R7 long counting disabled", int'(long_count), l0);
        cfg_short_en = 1'b1;
        cfg_long_en  = 1'b1;
    endtask

    task automatic t_bad_sop();
        int s0 = int'(short_count);
        send(5, 1'b1, 1'b0, 2);
        send(5, 1'b1, 1'b0, 4);
        chk("R2 double start pulse", int'(got_bsop), 1);
        chk("R2 stale packet not checked", int'(short_count), s0);
        send(5, 1'b0, 1'b1, 4);
        chk("R2 pulse lasts one cycle", int'(got_bsop), 0);
        chk("R2 new packet length 8 not short", int'(short_count), s0);
        send(5, 1'b1, 1'b0, 4);
        send(5, 1'b1, 1'b1, 3);
        chk("R2 start+end on open port pulse", int'(got_bsop), 1);
        idle();
        @(negedge clk);
        chk("R2 start+end completes 3-byte packet", int'(short_count), s0 + 1);
        chk("R4 faults low when idle", int'({evt_bad_sop, evt_bad_eop}), 0);
    endtask

    task automatic t_bad_eop();
        int s0 = int'(short_count);
        int l0 = int'(long_count);
        send(7, 1'b0, 1'b1, 4);
        chk("R3 end on closed port pulse", int'(got_beop), 1);
        chk("R4 no start fault with end fault", int'(got_bsop), 0);
        send(7, 1'b1, 1'b0, 4);
        chk("R3 pulse lasts one cycle", int'(got_beop), 0);
        send(7, 1'b0, 1'b1, 4);
        idle();
        chk("R3 dropped end did not count", int'(short_count), s0);
        chk("R3 long unchanged", int'(long_count), l0);
    endtask

    task automatic t_ignore();
        int s0 = int'(short_count);
        int f0 = n_bsop + n_beop;
        send(8, 1'b0, 1'b0, 4);
        send(8, 1'b0, 1'b0, 4);
        send(8, 1'b1, 1'b1, 4);
        idle();
        chk("R11 stray data not added to length", int'(short_count), s0 + 1);
        chk("R11 stray data raises no fault", n_bsop + n_beop, f0);
    endtask

    task automatic t_interleave();
        int s0 = int'(short_count);
        int l0 = int'(long_count);
        int f0 = n_bsop + n_beop;
        send(1, 1'b1, 1'b0, 4);
        send(2, 1'b1, 1'b0, 4);
        send(2, 1'b0, 1'b0, 4);
        send(1, 1'b0, 1'b1, 1);
        send(2, 1'b0, 1'b1, 4);
        idle();
        chk("R1 port 1 five bytes short", int'(short_count), s0 + 1);
        chk("R1 port 2 twelve bytes legal", int'(long_count), l0);
        chk("R10 interleaved no faults", n_bsop + n_beop, f0);
    endtask

    task automatic t_len_sat();
        int l0 = int'(long_count);
        cfg_max_len = 14'd16383;
        cfg_min_len = 8'd0;
        send_pkt(10, 16383);
        chk("R6 length 16383 at max not long", int'(long_count), l0);
        send_pkt(10, 32800);
        chk("R8 length past 32767 still long", int'(long_count), l0 + 1);
        idle();
        cfg_max_len = 14'd20;
        cfg_min_len = 8'd8;
    endtask

    task automatic t_cnt_sat();
        for (int i = 0; i < 20; i++) begin
            send_pkt(11, 1);
        end
        idle();
        chk("R9 short_count stops at all ones", int'(short_count), (1 << CW) - 1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_limits();
        t_disabled();
        t_bad_sop();
        t_bad_eop();
        t_ignore();
        t_interleave();
        t_len_sat();
        t_cnt_sat();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule